// File: doc/BRIEF.md
# AXI Slave Error-Mapping Bridge Front End

This block is the AXI4 slave side of a bridge that turns memory-mapped bursts into split transactions on a simple downstream port. An accepted read or write burst becomes a single downstream request carrying address, length and direction. Write beats are streamed downstream on a separate data channel. The block then waits for a completion. A completion carries data beats together with a poison bit and a completer-abort bit. The block then answers on the AXI R or B channel. Only one burst is in flight at a time.

Each distinct failure gets its own handling and its own sticky interrupt flag. These failures are a non-incrementing burst type, a read completion that never arrives, a poisoned completion and a completer abort. Data that belongs to a failed transfer is discarded. The master receives SLVERR on every affected beat. The flags are cleared by write-one-to-clear pulses, and their OR drives one interrupt line.

A central state machine sequences the work. From IDLE it takes AR first, then AW. A legal read goes IDLE → RD_REQ → RD_WAIT. From RD_WAIT a clean completion leads to RD_PASS. A poisoned or aborted completion leads to RD_DROP and then RD_ERR. An expired timer leads directly to RD_ERR. An illegal read goes IDLE → RD_ERR. A legal write goes IDLE → WR_REQ → WR_DATA → WR_WAIT → WR_RESP. An illegal write goes IDLE → WR_DRAIN → WR_RESP. RD_PASS and RD_ERR return to IDLE after the beat numbered by the burst length. WR_RESP returns to IDLE when BREADY is seen.

Top module: `axi_err_bridge`

## Requirements
- R1: A read burst whose burst field is not 2'b01 (incrementing) produces no downstream request. It sets flag bit 0 and returns ARLEN+1 beats with RRESP = 2'b10, RDATA = 0 and RLAST on the final beat.
- R2: A write burst whose burst field is not 2'b01 sets flag bit 0. It accepts all write beats up to WLAST and forwards none of them downstream, and it produces no downstream request. It then returns BRESP = 2'b10.
- R3: A forwarded read sets flag bit 1 and returns ARLEN+1 SLVERR beats if no completion is seen for tmo_limit cycles after the request handshake. The first error beat is taken exactly tmo_limit+1 cycles after that handshake when RREADY is held high.
- R4: A read completion whose first beat has cpl_poison set is consumed and discarded up to cpl_last. It sets flag bit 2, and the read returns ARLEN+1 beats with RRESP = 2'b10 and RDATA = 0. Poison takes precedence over abort.
- R5: A completion with cpl_abort set (and no poison) sets flag bit 3. It yields SLVERR beats with RDATA = 0 on a read, or BRESP = 2'b10 on a write.
- R6: A clean read completion is returned as ARLEN+1 beats in arrival order with RRESP = 2'b00 and RLAST only on the last beat. The downstream request shows direction 0, together with the captured address and length.
- R7: A legal write issues one request with direction 1, forwards every write beat in order with its last marker, and returns BRESP = 2'b00 after a clean completion.
- R8: The four flags (bit 0 illegal burst, bit 1 timeout, bit 2 poison, bit 3 abort) reset to zero and hold until the matching irq_clr bit is pulsed. The irq output is high exactly when any flag is set.
- R9: ARREADY and AWREADY stay low from an accepted burst until its response completes. When AR and AW are valid together, the read is taken first.
- R10: A completion arriving after its read has timed out is consumed and dropped. It changes neither the flags nor the data of the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TMO_W | Read completion timeout in cycles (0 acts as 1) |
| irq_clr | input | NUM_IRQ | Write-one-to-clear pulses for the flags |
| irq_flags | output | NUM_IRQ | Sticky error flags |
| irq | output | 1 | OR of all flags |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awlen | input | LEN_W | Write beats minus one |
| awburst | input | 2 | Write burst type |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wlast | input | 1 | Last write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read address |
| arlen | input | LEN_W | Read beats minus one |
| arburst | input | 2 | Read burst type |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Last read beat |
| dreq_valid | output | 1 | Downstream request valid |
| dreq_ready | input | 1 | Downstream request ready |
| dreq_write | output | 1 | Request direction, 1 = write |
| dreq_addr | output | ADDR_W | Request address |
| dreq_len | output | LEN_W | Request beats minus one |
| dwd_valid | output | 1 | Downstream write data valid |
| dwd_ready | input | 1 | Downstream write data ready |
| dwd_data | output | DATA_W | Downstream write data |
| dwd_last | output | 1 | Last downstream write beat |
| cpl_valid | input | 1 | Completion beat valid |
| cpl_ready | output | 1 | Completion beat ready |
| cpl_data | input | DATA_W | Completion data |
| cpl_last | input | 1 | Last completion beat |
| cpl_poison | input | 1 | Completion poisoned |
| cpl_abort | input | 1 | Completer abort status |

## Verification
The hold checks on R and B rely on two behaviours from the downstream side. A presented completion beat must keep cpl_valid asserted until it is taken. A read completion must carry exactly ARLEN+1 beats, and its status must sit on the first beat. The bench's completion driver meets both conditions: it holds each beat until cpl_ready is seen and always sends the requested beat count. The bench does not issue a new burst until the previous response has fully drained. Stray completions are sent only while the block is idle, which is where R10 applies.

// File: rtl/axi_err_bridge_pkg.sv
`timescale 1ns/1ps
package axi_err_bridge_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_RD_PASS,
        ST_RD_DROP,
        ST_RD_ERR,
        ST_WR_REQ,
        ST_WR_DATA,
        ST_WR_DRAIN,
        ST_WR_WAIT,
        ST_WR_RESP
    } brg_state_t;

    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam int FLG_ILLEGAL = 0;
    localparam int FLG_TIMEOUT = 1;
    localparam int FLG_POISON  = 2;
    localparam int FLG_ABORT   = 3;
    localparam int FLG_COUNT   = 4;

endpackage

// File: rtl/brg_cpl_timer.sv
`timescale 1ns/1ps
module brg_cpl_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam int CW = TMO_W + 1;

    logic [TMO_W-1:0] cnt_q;
    logic [CW-1:0]    cnt_next;
    logic [CW-1:0]    lim_ext;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + CW'(1);
        lim_ext  = {1'b0, limit};
        expired  = run && (cnt_next >= lim_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end
endmodule

// File: rtl/brg_beat_ctr.sv
`timescale 1ns/1ps
module brg_beat_ctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic             at_last
);
    logic [LEN_W-1:0] beat_q;

    assign at_last = (beat_q == len);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            beat_q <= '0;
        end else if (step && !at_last) begin
            beat_q <= beat_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/brg_irq_bank.sv
`timescale 1ns/1ps
module brg_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set[i]) begin
                flag_q <= 1'b1;
            end else if (clr[i]) begin
                flag_q <= 1'b0;
            end
        end
        assign flags[i] = flag_q;
    end

    assign any = |flags;
endmodule

// File: rtl/axi_err_bridge.sv
`timescale 1ns/1ps
module axi_err_bridge
    import axi_err_bridge_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int TMO_W   = 16,
    parameter int NUM_IRQ = FLG_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMO_W-1:0]   tmo_limit,
    input  logic [NUM_IRQ-1:0] irq_clr,
    output logic [NUM_IRQ-1:0] irq_flags,
    output logic               irq,
    input  logic               awvalid,
    output logic               awready,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic [LEN_W-1:0]   awlen,
    input  logic [1:0]         awburst,
    input  logic               wvalid,
    output logic               wready,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wlast,
    output logic               bvalid,
    input  logic               bready,
    output logic [1:0]         bresp,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic [LEN_W-1:0]   arlen,
    input  logic [1:0]         arburst,
    output logic               rvalid,
    input  logic               rready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rlast,
    output logic               dreq_valid,
    input  logic               dreq_ready,
    output logic               dreq_write,
    output logic [ADDR_W-1:0]  dreq_addr,
    output logic [LEN_W-1:0]   dreq_len,
    output logic               dwd_valid,
    input  logic               dwd_ready,
    output logic [DATA_W-1:0]  dwd_data,
    output logic               dwd_last,
    input  logic               cpl_valid,
    output logic               cpl_ready,
    input  logic [DATA_W-1:0]  cpl_data,
    input  logic               cpl_last,
    input  logic               cpl_poison,
    input  logic               cpl_abort
);
    brg_state_t         state_q, state_d;
    logic [LEN_W-1:0]   len_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [1:0]         bresp_q;
    logic [NUM_IRQ-1:0] flag_set;
    logic               tmo_exp;
    logic               beat_last;
    logic               r_hs;
    logic               cpl_bad;

    assign r_hs    = rvalid && rready;
    assign cpl_bad = cpl_poison || cpl_abort;

    brg_cpl_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_RD_WAIT),
        .limit   (tmo_limit),
        .expired (tmo_exp)
    );

    brg_beat_ctr #(.LEN_W(LEN_W)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_IDLE),
        .step    (r_hs),
        .len     (len_q),
        .at_last (beat_last)
    );

    brg_irq_bank #(.N(NUM_IRQ)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (irq_clr),
        .flags (irq_flags),
        .any   (irq)
    );

    // State register and captured burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            addr_q  <= '0;
            bresp_q <= RESP_OKAY;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (arvalid) begin
                    len_q  <= arlen;
                    addr_q <= araddr;
                end else if (awvalid) begin
                    len_q   <= awlen;
                    addr_q  <= awaddr;
                    bresp_q <= (awburst == BURST_INCR) ? RESP_OKAY : RESP_SLVERR;
                end
            end else if (state_q == ST_WR_WAIT && cpl_valid) begin
                bresp_q <= cpl_abort ? RESP_SLVERR : RESP_OKAY;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arvalid) begin
                    state_d = (arburst == BURST_INCR) ? ST_RD_REQ : ST_RD_ERR;
                end else if (awvalid) begin
                    state_d = (awburst == BURST_INCR) ? ST_WR_REQ : ST_WR_DRAIN;
                end
            end
            ST_RD_REQ:   if (dreq_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (cpl_valid) begin
                    state_d = cpl_bad ? ST_RD_DROP : ST_RD_PASS;
                end else if (tmo_exp) begin
                    state_d = ST_RD_ERR;
                end
            end
            ST_RD_PASS:  if (r_hs && beat_last) state_d = ST_IDLE;
            ST_RD_ERR:   if (r_hs && beat_last) state_d = ST_IDLE;
            ST_RD_DROP:  if (cpl_valid && cpl_last) state_d = ST_RD_ERR;
            ST_WR_REQ:   if (dreq_ready) state_d = ST_WR_DATA;
            ST_WR_DATA:  if (wvalid && dwd_ready && wlast) state_d = ST_WR_WAIT;
            ST_WR_DRAIN: if (wvalid && wlast) state_d = ST_WR_RESP;
            ST_WR_WAIT:  if (cpl_valid) state_d = ST_WR_RESP;
            ST_WR_RESP:  if (bready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output and flag-set logic
    always_comb begin
        arready    = 1'b0;
        awready    = 1'b0;
        wready     = 1'b0;
        bvalid     = 1'b0;
        bresp      = RESP_OKAY;
        rvalid     = 1'b0;
        rdata      = '0;
        rresp      = RESP_OKAY;
        rlast      = 1'b0;
        dreq_valid = 1'b0;
        dreq_write = 1'b0;
        dreq_addr  = addr_q;
        dreq_len   = len_q;
        dwd_valid  = 1'b0;
        dwd_data   = wdata;
        dwd_last   = wlast;
        cpl_ready  = 1'b0;
        flag_set   = '0;
        unique case (state_q)
            ST_IDLE: begin
                arready   = 1'b1;
                awready   = !arvalid;
                cpl_ready = 1'b1;
                if (arvalid) begin
                    flag_set[FLG_ILLEGAL] = (arburst != BURST_INCR);
                end else if (awvalid) begin
                    flag_set[FLG_ILLEGAL] = (awburst != BURST_INCR);
                end
            end
            ST_RD_REQ: begin
                dreq_valid = 1'b1;
                cpl_ready  = 1'b1;
            end
            ST_RD_WAIT: begin
                if (cpl_valid) begin
                    flag_set[FLG_POISON] = cpl_poison;
                    flag_set[FLG_ABORT]  = !cpl_poison && cpl_abort;
                end else begin
                    flag_set[FLG_TIMEOUT] = tmo_exp;
                end
            end
            ST_RD_PASS: begin
                rvalid    = cpl_valid;
                rdata     = cpl_data;
                rresp     = RESP_OKAY;
                rlast     = cpl_valid && beat_last;
                cpl_ready = rready;
            end
            ST_RD_DROP: begin
                cpl_ready = 1'b1;
            end
            ST_RD_ERR: begin
                rvalid    = 1'b1;
                rresp     = RESP_SLVERR;
                rlast     = beat_last;
                cpl_ready = 1'b1;
            end
            ST_WR_REQ: begin
                dreq_valid = 1'b1;
                dreq_write = 1'b1;
                cpl_ready  = 1'b1;
            end
            ST_WR_DATA: begin
                dwd_valid = wvalid;
                wready    = dwd_ready;
            end
            ST_WR_DRAIN: begin
                wready    = 1'b1;
                cpl_ready = 1'b1;
            end
            ST_WR_WAIT: begin
                cpl_ready = 1'b1;
                flag_set[FLG_ABORT] = cpl_valid && cpl_abort;
            end
            ST_WR_RESP: begin
                bvalid    = 1'b1;
                bresp     = bresp_q;
                cpl_ready = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/axi_err_bridge_chk.sv
`timescale 1ns/1ps
module axi_err_bridge_chk #(
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arvalid,
    input logic               arready,
    input logic [1:0]         arburst,
    input logic               awready,
    input logic               rvalid,
    input logic               rready,
    input logic [1:0]         rresp,
    input logic               rlast,
    input logic               bvalid,
    input logic               bready,
    input logic [1:0]         bresp,
    input logic               dreq_valid,
    input logic [NUM_IRQ-1:0] irq_flags,
    input logic [NUM_IRQ-1:0] irq_clr
);
    AST_ILLEGAL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready && arburst != 2'b01) |=> !dreq_valid); // R1

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid || bvalid) |-> !(arready || awready)); // R9

    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rlast))); // R6

    AST_R_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> !rvalid); // R6

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr))); // R8
endmodule

bind axi_err_bridge axi_err_bridge_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arvalid    (arvalid),
    .arready    (arready),
    .arburst    (arburst),
    .awready    (awready),
    .rvalid     (rvalid),
    .rready     (rready),
    .rresp      (rresp),
    .rlast      (rlast),
    .bvalid     (bvalid),
    .bready     (bready),
    .bresp      (bresp),
    .dreq_valid (dreq_valid),
    .irq_flags  (irq_flags),
    .irq_clr    (irq_clr)
);

// File: tb/axi_err_bridge_tb_top.sv
`timescale 1ns/1ps
module axi_err_bridge_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int TW = 16;
    localparam int NI = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] tmo_limit = TW'(200);
    logic [NI-1:0] irq_clr = '0;
    logic [NI-1:0] irq_flags;
    logic irq;
    logic awvalid = 0, awready; logic [AW-1:0] awaddr = '0; logic [LW-1:0] awlen = '0; logic [1:0] awburst = 2'b01;
    logic wvalid = 0, wready; logic [DW-1:0] wdata = '0; logic wlast = 0;
    logic bvalid, bready = 1'b1; logic [1:0] bresp;
    logic arvalid = 0, arready; logic [AW-1:0] araddr = '0; logic [LW-1:0] arlen = '0; logic [1:0] arburst = 2'b01;
    logic rvalid, rready = 1'b1; logic [DW-1:0] rdata; logic [1:0] rresp; logic rlast;
    logic dreq_valid, dreq_ready = 1'b1, dreq_write; logic [AW-1:0] dreq_addr; logic [LW-1:0] dreq_len;
    logic dwd_valid, dwd_ready = 1'b1, dwd_last; logic [DW-1:0] dwd_data;
    logic cpl_valid = 0, cpl_ready; logic [DW-1:0] cpl_data = '0; logic cpl_last = 0, cpl_poison = 0, cpl_abort = 0;

    always #10 clk = ~clk;

    axi_err_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit), .irq_clr(irq_clr), .irq_flags(irq_flags), .irq(irq),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen), .awburst(awburst),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen), .arburst(arburst),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
        .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_write(dreq_write), .dreq_addr(dreq_addr), .dreq_len(dreq_len),
        .dwd_valid(dwd_valid), .dwd_ready(dwd_ready), .dwd_data(dwd_data), .dwd_last(dwd_last),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data), .cpl_last(cpl_last),
        .cpl_poison(cpl_poison), .cpl_abort(cpl_abort)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    always @(negedge clk) cyc++;

    // Handshake monitors (sample pre-edge values at the active edge)
    logic [DW-1:0] r_dat [32]; logic [1:0] r_rsp [32]; logic r_lst [32];
    logic [DW-1:0] d_dat [32]; logic d_lst [32];
    int r_cnt = 0, w_cnt = 0, dwd_cnt = 0, dreq_cnt = 0, b_cnt = 0;
    int r_first_cyc = 0, r_last_cyc = 0, dreq_cyc = 0, ar_cyc = 0, aw_cyc = 0;
    logic dreq_wr_seen = 0, dreq_wr_first = 0; logic [LW-1:0] dreq_len_seen = '0; logic [AW-1:0] dreq_addr_seen = '0;
    logic [1:0] b_rsp_seen = '0;

    always @(posedge clk) if (rst_n) begin
        if (rvalid && rready) begin
            if (r_cnt < 32) begin r_dat[r_cnt] = rdata; r_rsp[r_cnt] = rresp; r_lst[r_cnt] = rlast; end
            if (r_cnt == 0) r_first_cyc = cyc;
            r_last_cyc = cyc;
            r_cnt++;
        end
        if (wvalid && wready) w_cnt++;
        if (dwd_valid && dwd_ready) begin
            if (dwd_cnt < 32) begin d_dat[dwd_cnt] = dwd_data; d_lst[dwd_cnt] = dwd_last; end
            dwd_cnt++;
        end
        if (dreq_valid && dreq_ready) begin
            if (dreq_cnt == 0) dreq_wr_first = dreq_write;
            dreq_wr_seen = dreq_write; dreq_len_seen = dreq_len; dreq_addr_seen = dreq_addr;
            dreq_cyc = cyc; dreq_cnt++;
        end
        if (bvalid && bready) begin b_rsp_seen = bresp; b_cnt++; end
        if (arvalid && arready) ar_cyc = cyc;
        if (awvalid && awready) aw_cyc = cyc;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        r_cnt = 0; w_cnt = 0; dwd_cnt = 0; dreq_cnt = 0; b_cnt = 0;
    endtask

    task automatic send_ar(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic [1:0] bt);
        @(negedge clk);
        araddr = a; arlen = l; arburst = bt; arvalid = 1'b1;
        do @(posedge clk); while (!arready);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    task automatic send_aw(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic [1:0] bt);
        @(negedge clk);
        awaddr = a; awlen = l; awburst = bt; awvalid = 1'b1;
        do @(posedge clk); while (!awready);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic send_w(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wvalid = 1'b1; wdata = base + DW'(i); wlast = (i == n - 1);
            do @(posedge clk); while (!wready);
        end
        @(negedge clk);
        wvalid = 1'b0; wlast = 1'b0;
    endtask

    task automatic send_cpl(input int n, input logic [DW-1:0] base, input logic psn, input logic abt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpl_valid = 1'b1; cpl_data = base + DW'(i); cpl_last = (i == n - 1);
            cpl_poison = psn; cpl_abort = abt;
            do @(posedge clk); while (!cpl_ready);
        end
        @(negedge clk);
        cpl_valid = 1'b0; cpl_last = 1'b0; cpl_poison = 1'b0; cpl_abort = 1'b0;
    endtask

    task automatic wait_dreq(input int n);
        while (dreq_cnt < n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [NI-1:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = '0;
        #1;
        chk("R8", "flags after W1C", 64'(irq_flags), 64'(0));
        chk("R8", "irq after W1C", 64'(irq), 64'(0));
    endtask

    task automatic check_err_beats(input string req, input int len);
        chk(req, "R beat count", 64'(r_cnt), 64'(len + 1));
        for (int i = 0; i <= len; i++) begin
            chk(req, "RRESP", 64'(r_rsp[i]), 64'(2'b10));
            chk(req, "RDATA", 64'(r_dat[i]), 64'(0));
            chk(req, "RLAST", 64'(r_lst[i]), 64'(i == len));
        end
    endtask

    task automatic t_reset();
        #1;
        chk("R8", "reset flags", 64'(irq_flags), 64'(0));
        chk("R8", "reset irq", 64'(irq), 64'(0));
        chk("R9", "reset arready", 64'(arready), 64'(1));
        chk("R9", "reset awready", 64'(awready), 64'(1));
        chk("R9", "reset rvalid", 64'(rvalid), 64'(0));
        chk("R9", "reset bvalid", 64'(bvalid), 64'(0));
        chk("R1", "reset dreq_valid", 64'(dreq_valid), 64'(0));
    endtask

    task automatic t_read_ok(input int len, input logic [DW-1:0] base);
        clear_mon();
        fork
            send_ar(32'h1000 + AW'(len), LW'(len), 2'b01);
            begin wait_dreq(1); repeat (3) @(negedge clk); send_cpl(len + 1, base, 1'b0, 1'b0); end
        join
        while (r_cnt < len + 1) @(negedge clk);
        repeat (2) @(negedge clk); #1;
        chk("R6", "request count", 64'(dreq_cnt), 64'(1));
        chk("R6", "request direction", 64'(dreq_wr_seen), 64'(0));
        chk("R6", "request length", 64'(dreq_len_seen), 64'(len));
        chk("R6", "request address", 64'(dreq_addr_seen), 64'(32'h1000 + len));
        chk("R6", "R beat count", 64'(r_cnt), 64'(len + 1));
        for (int i = 0; i <= len; i++) begin
            chk("R6", "RDATA", 64'(r_dat[i]), 64'(base + DW'(i)));
            chk("R6", "RRESP", 64'(r_rsp[i]), 64'(2'b00));
            chk("R6", "RLAST", 64'(r_lst[i]), 64'(i == len));
        end
        chk("R8", "flags after clean read", 64'(irq_flags), 64'(0));
    endtask

    task automatic t_read_illegal(input logic [1:0] bt, input int len);
        clear_mon();
        send_ar(32'h2000, LW'(len), bt);
        while (r_cnt < len + 1) @(negedge clk);
        repeat (2) @(negedge clk); #1;
        chk("R1", "no downstream request", 64'(dreq_cnt), 64'(0));
        check_err_beats("R1", len);
        chk("R1", "illegal flag", 64'(irq_flags), 64'(4'b0001));
        chk("R8", "irq follows flag", 64'(irq), 64'(1));
        clear_flags(4'b0001);
    endtask

    task automatic t_write_illegal(input logic [1:0] bt, input int len);
        clear_mon();
        fork
            send_aw(32'h3000, LW'(len), bt);
            send_w(len + 1, 32'hA0);
        join
        while (b_cnt < 1) @(negedge clk);
        @(negedge clk); #1;
        chk("R2", "W beats accepted", 64'(w_cnt), 64'(len + 1));
        chk("R2", "no data forwarded", 64'(dwd_cnt), 64'(0));
        chk("R2", "no downstream request", 64'(dreq_cnt), 64'(0));
        chk("R2", "BRESP", 64'(b_rsp_seen), 64'(2'b10));
        chk("R2", "illegal flag", 64'(irq_flags), 64'(4'b0001));
        clear_flags(4'b0001);
    endtask

    task automatic t_read_bad_cpl(input string req, input int len, input logic psn, input logic abt,
                                  input logic [NI-1:0] exp_flag);
        clear_mon();
        fork
            send_ar(32'h4000, LW'(len), 2'b01);
            begin wait_dreq(1); repeat (2) @(negedge clk); send_cpl(len + 1, 32'h5A50, psn, abt); end
        join
        while (r_cnt < len + 1) @(negedge clk);
        repeat (2) @(negedge clk); #1;
        check_err_beats(req, len);
        chk(req, "flag", 64'(irq_flags), 64'(exp_flag));
        chk(req, "completion drained", 64'(cpl_valid), 64'(0));
        clear_flags(exp_flag);
    endtask

    task automatic t_read_timeout(input int len, input int lim);
        clear_mon();
        @(negedge clk); tmo_limit = TW'(lim);
        send_ar(32'h6000, LW'(len), 2'b01);
        while (r_cnt < len + 1) @(negedge clk);
        repeat (2) @(negedge clk); #1;
        check_err_beats("R3", len);
        chk("R3", "first error beat delay", 64'(r_first_cyc - dreq_cyc), 64'(lim + 1));
        chk("R3", "timeout flag", 64'(irq_flags), 64'(4'b0010));
        // R10: late completion while idle is dropped
        send_cpl(len + 1, 32'hDEAD00, 1'b0, 1'b0);
        repeat (2) @(negedge clk); #1;
        chk("R10", "no R beats from late completion", 64'(r_cnt), 64'(len + 1));
        chk("R10", "flags unchanged by late completion", 64'(irq_flags), 64'(4'b0010));
        clear_flags(4'b0010);
        @(negedge clk); tmo_limit = TW'(200);
    endtask

    task automatic t_write(input int len, input logic abt);
        string req;
        req = abt ? "R5" : "R7";
        clear_mon();
        fork
            send_aw(32'h7000, LW'(len), 2'b01);
            send_w(len + 1, 32'hB00);
            begin
                wait_dreq(1);
                while (dwd_cnt < len + 1) @(negedge clk);
                repeat (2) @(negedge clk);
                send_cpl(1, 32'h0, 1'b0, abt);
            end
        join
        while (b_cnt < 1) @(negedge clk);
        @(negedge clk); #1;
        chk(req, "request direction", 64'(dreq_wr_seen), 64'(1));
        chk(req, "request length", 64'(dreq_len_seen), 64'(len));
        chk(req, "forwarded beats", 64'(dwd_cnt), 64'(len + 1));
        for (int i = 0; i <= len; i++) begin
            chk("R7", "forwarded data", 64'(d_dat[i]), 64'(32'hB00 + i));
            chk("R7", "forwarded last", 64'(d_lst[i]), 64'(i == len));
        end
        chk(req, "BRESP", 64'(b_rsp_seen), abt ? 64'(2'b10) : 64'(2'b00));
        chk(req, "flags", 64'(irq_flags), abt ? 64'(4'b1000) : 64'(0));
        if (abt) clear_flags(4'b1000);
    endtask

    task automatic t_priority();
        clear_mon();
        fork
            send_ar(32'h8000, LW'(1), 2'b01);
            send_aw(32'h9000, LW'(0), 2'b01);
            send_w(1, 32'hC00);
            begin
                wait_dreq(1);
                repeat (2) @(negedge clk);
                send_cpl(2, 32'h700, 1'b0, 1'b0);
                wait_dreq(2);
                while (dwd_cnt < 1) @(negedge clk);
                send_cpl(1, 32'h0, 1'b0, 1'b0);
            end
        join
        while (b_cnt < 1) @(negedge clk);
        @(negedge clk); #1;
        chk("R9", "read request issued first", 64'(dreq_wr_first), 64'(0));
        chk("R9", "AR before AW", 64'(ar_cyc < aw_cyc), 64'(1));
        chk("R9", "AW held until read done", 64'(aw_cyc > r_last_cyc), 64'(1));
        chk("R9", "read beats", 64'(r_cnt), 64'(2));
        chk("R9", "write response", 64'(b_rsp_seen), 64'(2'b00));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_ok(3, 32'h100);
        t_read_ok(0, 32'h200);
        t_read_illegal(2'b00, 2);
        t_read_illegal(2'b10, 0);
        t_read_illegal(2'b11, 3);
        t_write_illegal(2'b00, 3);
        t_write_illegal(2'b10, 0);
        t_read_timeout(2, 20);
        t_read_ok(2, 32'h300);
        t_read_bad_cpl("R4", 3, 1'b1, 1'b0, 4'b0100);
        t_read_bad_cpl("R4", 1, 1'b1, 1'b1, 4'b0100);
        t_read_bad_cpl("R5", 2, 1'b0, 1'b1, 4'b1000);
        t_write(3, 1'b0);
        t_write(0, 1'b1);
        t_priority();
        summary();
        $finish;
    end
endmodule